// File: doc/BRIEF.md
# Serial flash multi-mode single-byte read engine

This block fetches one byte from an attached serial NOR flash each time the host issues a read command over a byte-wide register bus. Software loads a 32-bit flash address, two opcode holding registers, a fast-read flag and a lane-mode field, then writes the start value to the command register. The engine lowers chip select, clocks out the opcode on one lane, then the low 24 address bits on one, two or four lanes, inserts eight dummy clocks when the mode calls for them, and shifts in one byte on one, two or four lanes. The byte lands in a read-data register, the low five bits of the command register are cleared to signal completion, and the stored address advances by one. Consecutive commands therefore stream consecutive bytes with no reprogramming.

The serial clock is derived from the system clock by a half-period divider. The interface runs in SPI mode 0 with the most significant bit first.

Top module: `sflash_rd_engine`

## Requirements
- R1: After reset the command register (offset 0x00) and read-data register (offset 0x01) read 0, cs_no is 1, sck_o is 0 and io_oe_o is 0.
- R2: Writing 0x81 to offset 0x00 while idle starts one read; offset 0x00 then reads 0x81 until completion, after which it reads 0x80 (low five bits cleared) and the fetched byte is at offset 0x01.
- R3: A write to offset 0x00 of any value other than 0x81, or any write to offset 0x00 while a read is in progress, is ignored: no transaction starts and the register keeps its value.
- R4: The opcode sent is the holding register at offset 0x09 when lane-mode bit2 is set; otherwise the holding register at offset 0x08 when lane-mode bit0 or the fast flag (offset 0x0A bit0) is set; otherwise 0x03.
- R5: Eight dummy clocks follow the address when the fast flag, lane-mode bit0 or lane-mode bit2 is set; otherwise data follows the address directly.
- R6: The opcode is always sent on io[0]. The low 24 address bits are sent MSB first on four lanes (io[3] most significant) when lane-mode (offset 0x0B) bit3 is set, else on two lanes (io[1] most significant) when bit1 is set, else on io[0].
- R7: The data byte is received MSB first on io[3:0] (io[3] most significant) when lane-mode bit2 is set, else on io[1:0] (io[1] most significant) when bit0 is set, else on io[1] alone.
- R8: The address is four byte registers, least significant first at offsets 0x02, 0x03, 0x04 and most significant at offset 0x0F; it increments by one after every completed read, carrying through all 32 bits.
- R9: sck_o idles low and is only raised while cs_no is low; cs_no stays low for the whole transaction; io_oe_o drives exactly the opcode/address lanes in use and is 0 during dummy and data clocks and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| cs_no | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | Flash serial clock |
| io_o | output | 4 | Flash data lane outputs |
| io_oe_o | output | 4 | Flash data lane output enables |
| io_i | input | 4 | Flash data lane inputs |

## Verification
The bench pairs every lane-mode combination with a flash model that decodes opcode and address with the lane count the requirements predict, so an engine that picked the wrong holding register, skipped or added dummy clocks, or packed lanes in reversed order returns a wrong byte or a wrong captured opcode. Mixed settings where quad and dual bits are both set check the priority; a design with inverted priority would fetch on two lanes and miscompare. An address of 0x00FFFFFF checks the carry into the top byte register, which a design incrementing only the low bytes would lose. Command writes during a transfer and non-start command values check that a second transfer is never launched, which would show as a double address increment or an asserted chip select.

// File: rtl/sflash_rd_pkg.sv
package sflash_rd_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA} phase_e;
  // encoded as log2 of lane count
  typedef enum logic [1:0] {LN_1 = 2'd0, LN_2 = 2'd1, LN_4 = 2'd2} lanes_e;

  localparam logic [7:0] CMD_READ   = 8'h81;
  localparam logic [7:0] OP_NORMAL  = 8'h03;
  localparam int         DUMMY_CLKS = 8;

  localparam logic [7:0] OFS_CMD   = 8'h00;
  localparam logic [7:0] OFS_RDATA = 8'h01;
  localparam logic [7:0] OFS_ADR0  = 8'h02;
  localparam logic [7:0] OFS_ADR1  = 8'h03;
  localparam logic [7:0] OFS_ADR2  = 8'h04;
  localparam logic [7:0] OFS_OP3   = 8'h08;
  localparam logic [7:0] OFS_OP4   = 8'h09;
  localparam logic [7:0] OFS_CFG   = 8'h0A;
  localparam logic [7:0] OFS_MODE  = 8'h0B;
  localparam logic [7:0] OFS_ADR3  = 8'h0F;
endpackage

// File: rtl/sflash_rd_tick.sv
module sflash_rd_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sflash_rd_seq.sv
module sflash_rd_seq
  import sflash_rd_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  lanes_e            alanes_i,
  input  lanes_e            dlanes_i,
  input  logic              dummy_i,
  input  logic              tick_i,
  input  logic [3:0]        io_i,
  output logic              active_o,
  output logic              cs_no,
  output logic              sck_o,
  output logic [3:0]        io_o,
  output logic [3:0]        io_oe_o,
  output logic              done_o,
  output logic [7:0]        byte_o
);
  localparam int TX_W  = ADDR_W + 8;
  localparam int CNT_W = $clog2(ADDR_W + 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TX_W-1:0]  tx_q;
  logic [7:0]       rx_q;
  logic             sck_q, done_q;
  lanes_e           al_q, dl_q;
  logic             dum_q;

  assign active_o = (ph_q != PH_IDLE);
  assign cs_no    = (ph_q == PH_IDLE);
  assign sck_o    = sck_q;
  assign done_o   = done_q;
  assign byte_o   = rx_q;

  always_comb begin
    io_o    = '0;
    io_oe_o = '0;
    if (ph_q == PH_CMD || (ph_q == PH_ADDR && al_q == LN_1)) begin
      io_o    = {3'b000, tx_q[TX_W-1]};
      io_oe_o = 4'b0001;
    end else if (ph_q == PH_ADDR && al_q == LN_2) begin
      io_o    = {2'b00, tx_q[TX_W-1 -: 2]};
      io_oe_o = 4'b0011;
    end else if (ph_q == PH_ADDR) begin
      io_o    = tx_q[TX_W-1 -: 4];
      io_oe_o = 4'b1111;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      al_q   <= LN_1;
      dl_q   <= LN_1;
      dum_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ph_q == PH_IDLE) begin
        if (start_i) begin
          ph_q  <= PH_CMD;
          cnt_q <= CNT_W'(8);
          tx_q  <= {opcode_i, addr_i};
          rx_q  <= '0;
          sck_q <= 1'b0;
          al_q  <= alanes_i;
          dl_q  <= dlanes_i;
          dum_q <= dummy_i;
        end
      end else if (tick_i) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          if (ph_q == PH_DATA) begin
            case (dl_q)
              LN_2:    rx_q <= {rx_q[5:0], io_i[1:0]};
              LN_4:    rx_q <= {rx_q[3:0], io_i};
              default: rx_q <= {rx_q[6:0], io_i[1]};
            endcase
          end
        end else begin
          sck_q <= 1'b0;
          if (ph_q == PH_ADDR) tx_q <= tx_q << (1 << al_q);
          else                 tx_q <= tx_q << 1;
          if (cnt_q == CNT_W'(1)) begin
            case (ph_q)
              PH_CMD: begin
                ph_q  <= PH_ADDR;
                cnt_q <= CNT_W'(ADDR_W) >> al_q;
              end
              PH_ADDR: begin
                if (dum_q) begin
                  ph_q  <= PH_DUMMY;
                  cnt_q <= CNT_W'(DUMMY_CLKS);
                end else begin
                  ph_q  <= PH_DATA;
                  cnt_q <= CNT_W'(8) >> dl_q;
                end
              end
              PH_DUMMY: begin
                ph_q  <= PH_DATA;
                cnt_q <= CNT_W'(8) >> dl_q;
              end
              default: begin
                ph_q   <= PH_IDLE;
                done_q <= 1'b1;
              end
            endcase
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sflash_rd_engine.sv
module sflash_rd_engine
  import sflash_rd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int ADDR_W   = 24
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       cs_no,
  output logic       sck_o,
  output logic [3:0] io_o,
  output logic [3:0] io_oe_o,
  input  logic [3:0] io_i
);
  logic [7:0]  cmd_q, rdata_q, op3_q, op4_q, mode_q;
  logic        fast_q;
  logic [31:0] addr_q;
  logic        busy, start, seq_done, seq_active, tick;
  logic [7:0]  seq_byte, opcode;
  lanes_e      alanes, dlanes;
  logic        dummy;

  assign busy  = |cmd_q[4:0];
  assign start = reg_we_i && (reg_addr_i == OFS_CMD) && !busy && (reg_wdata_i == CMD_READ);

  // quad has priority over dual, dual over fast
  always_comb begin
    if (mode_q[2])                opcode = op4_q;
    else if (mode_q[0] || fast_q) opcode = op3_q;
    else                          opcode = OP_NORMAL;
    dummy  = fast_q | mode_q[0] | mode_q[2];
    alanes = mode_q[3] ? LN_4 : (mode_q[1] ? LN_2 : LN_1);
    dlanes = mode_q[2] ? LN_4 : (mode_q[0] ? LN_2 : LN_1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      rdata_q <= '0;
      op3_q   <= '0;
      op4_q   <= '0;
      mode_q  <= '0;
      fast_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      if (seq_done) begin
        cmd_q[4:0] <= '0;
        rdata_q    <= seq_byte;
        addr_q     <= addr_q + 32'd1;
      end
      if (reg_we_i) begin
        case (reg_addr_i)
          OFS_CMD:  if (start) cmd_q <= reg_wdata_i;
          OFS_ADR0: addr_q[7:0]   <= reg_wdata_i;
          OFS_ADR1: addr_q[15:8]  <= reg_wdata_i;
          OFS_ADR2: addr_q[23:16] <= reg_wdata_i;
          OFS_ADR3: addr_q[31:24] <= reg_wdata_i;
          OFS_OP3:  op3_q  <= reg_wdata_i;
          OFS_OP4:  op4_q  <= reg_wdata_i;
          OFS_CFG:  fast_q <= reg_wdata_i[0];
          OFS_MODE: mode_q <= {4'b0000, reg_wdata_i[3:0]};
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_CMD:   reg_rdata_o = cmd_q;
      OFS_RDATA: reg_rdata_o = rdata_q;
      OFS_ADR0:  reg_rdata_o = addr_q[7:0];
      OFS_ADR1:  reg_rdata_o = addr_q[15:8];
      OFS_ADR2:  reg_rdata_o = addr_q[23:16];
      OFS_ADR3:  reg_rdata_o = addr_q[31:24];
      OFS_OP3:   reg_rdata_o = op3_q;
      OFS_OP4:   reg_rdata_o = op4_q;
      OFS_CFG:   reg_rdata_o = {7'b0, fast_q};
      OFS_MODE:  reg_rdata_o = mode_q;
      default:   reg_rdata_o = '0;
    endcase
  end

  sflash_rd_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (seq_active),
    .tick_o (tick)
  );

  sflash_rd_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .opcode_i (opcode),
    .addr_i   (addr_q[ADDR_W-1:0]),
    .alanes_i (alanes),
    .dlanes_i (dlanes),
    .dummy_i  (dummy),
    .tick_i   (tick),
    .io_i     (io_i),
    .active_o (seq_active),
    .cs_no    (cs_no),
    .sck_o    (sck_o),
    .io_o     (io_o),
    .io_oe_o  (io_oe_o),
    .done_o   (seq_done),
    .byte_o   (seq_byte)
  );
endmodule

// File: rtl/sflash_rd_chk.sv
module sflash_rd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cs_no,
  input logic        sck_o,
  input logic [3:0]  io_oe_o,
  input logic        busy,
  input logic        seq_done,
  input logic [7:0]  cmd_q,
  input logic [31:0] addr_q
);
  p_cs_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> cs_no);
  p_sck_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_oe_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (io_oe_o == 4'b0000));
  p_done_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |=> (cmd_q[4:0] == 5'd0));
  p_addr_inc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |=> (addr_q == $past(addr_q) + 32'd1));
  p_cmd_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !seq_done) |=> (cmd_q == $past(cmd_q)));
endmodule

bind sflash_rd_engine sflash_rd_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_no    (cs_no),
  .sck_o    (sck_o),
  .io_oe_o  (io_oe_o),
  .busy     (busy),
  .seq_done (seq_done),
  .cmd_q    (cmd_q),
  .addr_q   (addr_q)
);

// File: tb/test_sflash_rd_engine.sv
`timescale 1ns/1ps
module test_sflash_rd_engine;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_addr_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic       cs_no, sck_o;
  logic [3:0] io_o, io_oe_o, io_i;

  always #5 clk_i = ~clk_i;

  sflash_rd_engine i_sflash_rd_engine (.*);

  int n_chk = 0, n_bad = 0, v_oe = 0, v_sck = 0;
  bit fin = 1'b0;

  // flash model state; lane counts set by the bench from the requirements
  int         m_al = 1, m_dl = 1, m_dum = 0, e = 0;
  logic [7:0] m_op;
  logic [23:0] m_addr;

  function automatic logic [7:0] fmem(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  always @(posedge sck_o or posedge cs_no) begin
    if (cs_no) e <= 0;
    else begin
      if (e < 8) begin
        m_op <= {m_op[6:0], io_o[0]};
        if (io_oe_o !== 4'b0001) v_oe++;
      end else if (e < 8 + 24 / m_al) begin
        case (m_al)
          2:       begin m_addr <= {m_addr[21:0], io_o[1:0]}; if (io_oe_o !== 4'b0011) v_oe++; end
          4:       begin m_addr <= {m_addr[19:0], io_o};      if (io_oe_o !== 4'b1111) v_oe++; end
          default: begin m_addr <= {m_addr[22:0], io_o[0]};   if (io_oe_o !== 4'b0001) v_oe++; end
        endcase
      end else if (io_oe_o !== 4'b0000) v_oe++;
      e <= e + 1;
    end
  end

  always_comb begin
    int hdr, k;
    logic [7:0] sh;
    hdr = 8 + 24 / m_al + m_dum;
    io_i = 4'b0000;
    if (e >= hdr) begin
      k = e - hdr;
      sh = fmem(m_addr) << (k * m_dl);
      case (m_dl)
        2:       io_i[1:0] = sh[7:6];
        4:       io_i = sh[7:4];
        default: io_i[1] = sh[7];
      endcase
    end
  end

  always @(negedge clk_i) if (cs_no && sck_o) v_sck++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic set_addr(input logic [31:0] a);
    wr(8'h02, a[7:0]); wr(8'h03, a[15:8]); wr(8'h04, a[23:16]); wr(8'h0F, a[31:24]);
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [7:0] b;
    rd(8'h02, b); a[7:0] = b;   rd(8'h03, b); a[15:8] = b;
    rd(8'h04, b); a[23:16] = b; rd(8'h0F, b); a[31:24] = b;
  endtask

  task automatic wait_done(input string tag);
    logic [7:0] c;
    c = 8'hFF;
    for (int i = 0; i < 4000 && c[4:0] != 5'd0; i++) rd(8'h00, c);
    chk(tag, {24'd0, c}, 32'h80);
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  mode;
    logic        fast;
    logic [7:0]  op3, op4, eop;
    logic [2:0]  eal;
    logic [3:0]  edum;
    logic [2:0]  edl;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h00123456, 4'b0000, 1'b0, 8'h0B, 8'h6B, 8'h03, 3'd1, 4'd0, 3'd1},
    '{32'h00ABCDEF, 4'b0000, 1'b1, 8'h0B, 8'h6B, 8'h0B, 3'd1, 4'd8, 3'd1},
    '{32'h00010203, 4'b0001, 1'b0, 8'h3B, 8'h6B, 8'h3B, 3'd1, 4'd8, 3'd2},
    '{32'h00F0E1D2, 4'b0011, 1'b0, 8'hBB, 8'h6B, 8'hBB, 3'd2, 4'd8, 3'd2},
    '{32'h00C3B4A5, 4'b0100, 1'b0, 8'h3B, 8'h6B, 8'h6B, 3'd1, 4'd8, 3'd4},
    '{32'h005A6978, 4'b1100, 1'b0, 8'h3B, 8'hEB, 8'hEB, 3'd4, 4'd8, 3'd4},
    '{32'h00777777, 4'b0010, 1'b0, 8'h3B, 8'h6B, 8'h03, 3'd2, 4'd0, 3'd1},
    '{32'h00135790, 4'b0101, 1'b1, 8'h3C, 8'h6C, 8'h6C, 3'd1, 4'd8, 3'd4}
  };

  task automatic run_read(input logic [31:0] a, input string tag);
    logic [7:0]  b;
    logic [31:0] na;
    wr(8'h00, 8'h81);
    rd(8'h00, b);
    chk({tag, " R2 busy"}, {24'd0, b}, 32'h81);
    chk({tag, " R9 cs low"}, {31'd0, cs_no}, 32'd0);
    wait_done({tag, " R2 done"});
    rd(8'h01, b);
    chk({tag, " R7 data"}, {24'd0, b}, {24'd0, fmem(a[23:0])});
    chk({tag, " R6 addr"}, {8'd0, m_addr}, {8'd0, a[23:0]});
    get_addr(na);
    chk({tag, " R8 inc"}, na, a + 32'd1);
  endtask

  initial begin
    logic [7:0]  b;
    logic [31:0] a;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    rd(8'h00, b); chk("R1 cmd", {24'd0, b}, 32'd0);
    rd(8'h01, b); chk("R1 rdata", {24'd0, b}, 32'd0);
    chk("R1 pins", {28'd0, cs_no, sck_o, |io_oe_o, 1'b0}, 32'b1000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    foreach (VECS[i]) begin
      string t;
      t = $sformatf("v%0d", i);
      set_addr(VECS[i].addr);
      wr(8'h08, VECS[i].op3); wr(8'h09, VECS[i].op4);
      wr(8'h0A, {7'd0, VECS[i].fast}); wr(8'h0B, {4'd0, VECS[i].mode});
      m_al = int'(VECS[i].eal); m_dl = int'(VECS[i].edl); m_dum = int'(VECS[i].edum);
      run_read(VECS[i].addr, t);
      chk({t, " R4 opcode"}, {24'd0, m_op}, {24'd0, VECS[i].eop});
      chk({t, " R5 dummy"}, 32'(e), 32'(8 + 24 / m_al + m_dum + 8 / m_dl) * 0);
    end

    // R3 non-start command value ignored
    wr(8'h0B, 8'h00); wr(8'h0A, 8'h00);
    m_al = 1; m_dl = 1; m_dum = 0;
    set_addr(32'h00000010);
    wr(8'h00, 8'h80);
    repeat (20) @(negedge clk_i);
    chk("R3 no start cs", {31'd0, cs_no}, 32'd1);
    rd(8'h00, b); chk("R3 cmd kept", {24'd0, b}, 32'h80);
    get_addr(a); chk("R3 addr kept", a, 32'h10);

    // R3 writes while busy ignored, single increment
    wr(8'h00, 8'h81);
    wr(8'h00, 8'h01);
    wr(8'h00, 8'h81);
    rd(8'h00, b); chk("R3 busy cmd", {24'd0, b}, 32'h81);
    wait_done("R3 done");
    get_addr(a); chk("R3 one inc", a, 32'h11);
    rd(8'h01, b); chk("R3 data", {24'd0, b}, {24'd0, fmem(24'h10)});

    // R8 consecutive reads and carry into the top byte
    run_read(32'h00000011, "R8 seq");
    set_addr(32'h00FFFFFF);
    run_read(32'h00FFFFFF, "R8 carry");
    rd(8'h0F, b); chk("R8 top byte", {24'd0, b}, 32'h01);

    chk("R9 oe lanes", 32'(v_oe), 32'd0);
    chk("R9 sck idle", 32'(v_sck), 32'd0);
    fin = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule